// File: doc/BRIEF.md
# Strobe-Driven Parallel Programming Target

This block sits on the target side of a parallel programming link to a word memory. An external programmer drives a 16-bit bus and three active-low strobes. The address strobe sets up an operation, the program strobe brackets each write or read-out, and the advance strobe steps through consecutive words. All three strobes are asynchronous to the block clock. Each one passes through a two-flop synchronizer, and the block acts on edges of the synchronized level.

The programmer uses two address-strobe falls to set up an operation. The first carries a command word and the second carries the word address. In program mode, each program-strobe fall latches a data word. The block then applies timed write pulses to the addressed location for as long as the strobe stays low. The stored cells behave like one-time cells: a pulse can clear bits but never set them. After each pulse the block reads the word back and reports the result on a per-pulse pass output. A cumulative pass output drops on the first mismatch and stays low.

In dump mode, the program strobe instead places the addressed word on the bus for as long as it is held. The open-drain bus is modelled as an output-enable plus output-data pair. When a location completes, the advance strobe is sampled. If it is low, the block moves to the next address without a new address phase.

Top module: `prog_port_ctrl`

## Requirements
- R1: After reset, bus_oe_o is low and both pass_o and cum_pass_o are high. The block waits for a command. Every memory word reads 16'hFFFF after power-up.
- R2: Setup takes two steps. On the first accepted address-strobe fall, the bus value is taken as the command: 16'h0000 selects program and 16'h0001 selects dump. On the next address-strobe fall, bus bits [AW-1:0] are taken as the word address.
- R3: A command word other than 16'h0000 or 16'h0001 is ignored. The current state, mode and address are kept.
- R4: In program mode, a program-strobe fall latches the bus data. Each pulse stores (old word AND data). Pulses repeat with the same data while the strobe stays low.
- R5: After every pulse, pass_o is set high if the read-back word equals the latched data, and low otherwise.
- R6: cum_pass_o goes low after any failing pulse. It returns high only on reset. A later passing pulse leaves it low.
- R7: In dump mode, bus_oe_o is high and bus_o holds the addressed word while the program strobe is low. bus_oe_o falls after the strobe rises, and it is never high outside dump mode.
- R8: When a location completes, the address becomes (address + 1) mod 2^AW if the advance strobe is low. If the advance strobe is high, the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_n_i | input | 1 | Active-low address/command strobe, asynchronous |
| prog_n_i | input | 1 | Active-low program/dump strobe, asynchronous |
| ainc_n_i | input | 1 | Active-low advance strobe, asynchronous |
| bus_i | input | DW | Bus value seen at the pins |
| bus_oe_o | output | 1 | Bus output enable (pull-down drive active) |
| bus_o | output | DW | Bus value driven while enabled |
| pass_o | output | 1 | Result of the latest pulse's read-back compare |
| cum_pass_o | output | 1 | High while every pulse so far has passed |

## Verification
The bench programs a location that is already programmed with a word needing a cleared bit set back to one. A design that overwrites instead of ANDing would wrongly report a pass, and a design with a non-sticky cumulative flag would recover on the next good word. It programs the top address with the advance strobe held low and then dumps across the wrap. An address counter that saturates, or that steps when the strobe is high, returns the wrong word. An invalid command is sent while in dump mode: a design that treats it as a command, or shifts it into the address phase, dumps from the wrong location or drives the bus in the wrong mode.

// File: rtl/prog_port_pkg.sv
package prog_port_pkg;
  localparam logic [15:0] CMD_PROG = 16'h0000;
  localparam logic [15:0] CMD_DUMP = 16'h0001;

  typedef enum logic [3:0] {
    S_CMD,    // waiting for a command word
    S_ADDR,   // waiting for the address word
    S_IDLE,   // set up, waiting for program strobe
    S_PWAIT,  // pulse width running
    S_PWR,    // write strobe to memory
    S_PRD,    // read-back issued
    S_PCMP,   // compare read-back with latched data
    S_DRD,    // dump: load output register
    S_DHOLD,  // dump: bus driven until strobe rises
    S_STEP    // location done, sample advance strobe
  } port_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic m1, m2, m3;
    always_ff @(posedge clk) begin
      if (rst) begin
        m1 <= 1'b1;
        m2 <= 1'b1;
        m3 <= 1'b1;
      end else begin
        m1 <= raw_n[i];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign lvl_n[i] = m2;
    assign fall[i]  = m3 & ~m2;
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/prog_port_ctrl.sv
module prog_port_ctrl
  import prog_port_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 6,
  parameter int PULSE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_n_i,
  input  logic          prog_n_i,
  input  logic          ainc_n_i,
  input  logic [DW-1:0] bus_i,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_o,
  output logic          pass_o,
  output logic          cum_pass_o
);
  localparam int CW = $clog2(PULSE_CYC) + 1;

  logic [2:0] lvl_n, fall;
  logic       ale_fall, prog_fall, prog_lvl_n, ainc_lvl_n;

  strobe_sync #(.N(3)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_n ({ainc_n_i, prog_n_i, ale_n_i}),
    .lvl_n (lvl_n),
    .fall  (fall)
  );

  assign ale_fall   = fall[0];
  assign prog_fall  = fall[1];
  assign prog_lvl_n = lvl_n[1];
  assign ainc_lvl_n = lvl_n[2];

  port_state_e   st;
  logic          mode_dump;
  logic [AW-1:0] addr;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rdata;
  logic [CW-1:0] cnt;
  logic          mem_we;
  logic          cmd_ok;

  assign cmd_ok = (bus_i == DW'(CMD_PROG)) || (bus_i == DW'(CMD_DUMP));
  assign mem_we = (st == S_PWR);

  word_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr),
    .wdata (rdata & data_q),
    .rdata (rdata)
  );

  // pulse width counter, runs only inside the wait state
  always_ff @(posedge clk) begin
    if (rst || st != S_PWAIT) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_CMD;
      mode_dump  <= 1'b0;
      addr       <= '0;
      data_q     <= '0;
      bus_oe_o   <= 1'b0;
      bus_o      <= '0;
      pass_o     <= 1'b1;
      cum_pass_o <= 1'b1;
    end else begin
      unique case (st)
        S_CMD: begin
          if (ale_fall && cmd_ok) begin
            mode_dump <= (bus_i == DW'(CMD_DUMP));
            st        <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (ale_fall) begin
            addr <= bus_i[AW-1:0];
            st   <= S_IDLE;
          end
        end
        S_IDLE: begin
          if (ale_fall) begin
            if (cmd_ok) begin
              mode_dump <= (bus_i == DW'(CMD_DUMP));
              st        <= S_ADDR;
            end
          end else if (prog_fall) begin
            if (mode_dump) st <= S_DRD;
            else begin
              data_q <= bus_i;
              st     <= S_PWAIT;
            end
          end
        end
        S_PWAIT: if (cnt == CW'(PULSE_CYC - 1)) st <= S_PWR;
        S_PWR:   st <= S_PRD;
        S_PRD:   st <= S_PCMP;
        S_PCMP: begin
          pass_o <= (rdata == data_q);
          if (rdata != data_q) cum_pass_o <= 1'b0;
          st <= prog_lvl_n ? S_STEP : S_PWAIT;
        end
        S_DRD: begin
          bus_o    <= rdata;
          bus_oe_o <= 1'b1;
          st       <= S_DHOLD;
        end
        S_DHOLD: begin
          if (prog_lvl_n) begin
            bus_oe_o <= 1'b0;
            st       <= S_STEP;
          end
        end
        S_STEP: begin
          if (!ainc_lvl_n) addr <= addr + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_CMD;
      endcase
    end
  end
endmodule

// File: rtl/prog_port_ctrl_chk.sv
module prog_port_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_oe_o,
  input logic [DW-1:0] bus_o,
  input logic          pass_o,
  input logic          cum_pass_o,
  input logic          mode_dump,
  input logic          mem_we
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cum_pass_o && pass_o && !bus_oe_o));

  // R7
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> mode_dump);

  // R7
  oe_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_o));

  // R6
  cum_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !cum_pass_o |=> !cum_pass_o);

  // R6
  cum_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cum_pass_o) |-> !pass_o);

  // R4
  write_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!mode_dump && !bus_oe_o));
endmodule

bind prog_port_ctrl prog_port_ctrl_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_oe_o   (bus_oe_o),
  .bus_o      (bus_o),
  .pass_o     (pass_o),
  .cum_pass_o (cum_pass_o),
  .mode_dump  (mode_dump),
  .mem_we     (mem_we)
);

// File: tb/prog_port_ctrl_test.sv
module prog_port_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          ale_n = 1'b1, prog_n = 1'b1, ainc_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic          oe, pass, cum;
  logic [DW-1:0] bus_out;

  prog_port_ctrl #(.DW(DW), .AW(AW), .PULSE_CYC(8)) uut (
    .clk        (clk),
    .rst        (rst),
    .ale_n_i    (ale_n),
    .prog_n_i   (prog_n),
    .ainc_n_i   (ainc_n),
    .bus_i      (bus_in),
    .bus_oe_o   (oe),
    .bus_o      (bus_out),
    .pass_o     (pass),
    .cum_pass_o (cum)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];
  logic [AW-1:0] m_addr;
  logic          m_cum;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic word_ok(logic [DW-1:0] old, logic [DW-1:0] d);
    return ((old & d) == d);
  endfunction

  task automatic strobe_ale(logic [DW-1:0] w);
    @(negedge clk);
    bus_in = w;
    ale_n  = 1'b0;
    idle(6);
    ale_n  = 1'b1;
    idle(6);
  endtask

  task automatic setup(logic [DW-1:0] cmd, logic [AW-1:0] a);
    strobe_ale(cmd);
    strobe_ale(DW'(a));
    m_addr = a;
  endtask

  task automatic do_prog(logic [DW-1:0] d, bit inc);
    logic ok;
    @(negedge clk);
    bus_in = d;
    ainc_n = !inc;
    prog_n = 1'b0;
    idle(40);
    chk("R7 no drive while programming", oe, 1'b0);
    prog_n = 1'b1;
    idle(30);
    ainc_n = 1'b1;
    ok = word_ok(model[m_addr], d);
    model[m_addr] = model[m_addr] & d;
    if (!ok) m_cum = 1'b0;
    chk("R5 pass after pulse", pass, ok);
    chk("R6 cumulative pass", cum, m_cum);
    if (inc) m_addr = m_addr + 1'b1;
  endtask

  task automatic do_dump(bit inc);
    @(negedge clk);
    ainc_n = !inc;
    prog_n = 1'b0;
    idle(10);
    chk("R7 oe during dump", oe, 1'b1);
    chk("R4 R8 dumped word", bus_out, model[m_addr]);
    prog_n = 1'b1;
    idle(30);
    ainc_n = 1'b1;
    chk("R7 oe released", oe, 1'b0);
    if (inc) m_addr = m_addr + 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    m_cum  = 1'b1;
    m_addr = '0;
    void'($urandom(32'h5eed_1234));
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 oe", oe, 1'b0);
    chk("R1 pass", pass, 1'b1);
    chk("R1 cum", cum, 1'b1);

    // R2 dump erased word, then program and read back (R4)
    setup(16'h0001, 6'd5);
    do_dump(1'b0);
    setup(16'h0000, 6'd5);
    do_prog(16'hA5C3, 1'b0);
    setup(16'h0001, 6'd5);
    do_dump(1'b0);

    // R3 bad command in dump mode: mode and address kept
    strobe_ale(16'h0007);
    do_dump(1'b0);
    strobe_ale(16'h8001);
    do_dump(1'b0);

    // R8 wrap at top address, then a failing re-program (R5, R6)
    setup(16'h0000, 6'd63);
    do_prog(16'h00FF, 1'b1);
    chk("R8 model wrapped", m_addr, 0);
    do_prog(16'h1234, 1'b0);
    do_prog(16'hFFFF, 1'b0);
    setup(16'h0001, 6'd63);
    do_dump(1'b1);
    do_dump(1'b0);
    // R6 a later good pulse keeps cum low
    setup(16'h0000, 6'd10);
    do_prog(16'h0F0F, 1'b0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      bit            is_dump;
      bit            inc;
      logic [AW-1:0] a;
      is_dump = $urandom % 2;
      inc     = $urandom % 2;
      a       = ($urandom % 2) ? AW'($urandom) : m_addr;
      setup(is_dump ? 16'h0001 : 16'h0000, a);
      if (is_dump) do_dump(inc);
      else         do_prog(DW'($urandom) | DW'($urandom), inc);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule